// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks even parity for a 64-bit multiplexed address/data bus that carries active-low command/byte-enable lines. Every clock it samples the bus together with the frame, initiator-ready, target-ready and device-select strobes. It also samples three flags from the surrounding bus interface: the agent's role (initiator or target), the transfer direction, and whether a 64-bit transfer was negotiated. From these it decides, cycle by cycle, whether this agent must drive the parity lines one clock later, and whether it must check the parity that another agent returns.

Parity is driven for the address phase by the initiator. For data it is driven by whichever agent sources the data, one clock after that agent's ready strobe is low. Checking runs only on completed data phases that this agent receives and that were claimed through device-select. A data error drives the data-error line low two clocks after the data phase completes. An address error, which only a target checks, drives the system-error line low for exactly one clock. Both kinds of error also set sticky flags, which the surrounding logic clears with one-clock clear pulses.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_out` in cycle k+1 equals the XOR of `ad[31:0]` and `cbe_n[3:0]` sampled in cycle k, so that the 37 bits hold an even number of ones.
- R2: `par64_out` in cycle k+1 is the even parity over all of `ad[63:0]` and `cbe_n[7:0]` of cycle k. `par64_oe` is high only for data phases driven while `wide64` is high, and never for an address phase.
- R3: An address phase is a cycle with `frame_n` low that follows a cycle with both `frame_n` and `irdy_n` high. When `is_master` is 1, `par_oe` is 1 in the next cycle. When `is_master` is 0, `par_oe` is 0 in the next cycle.
- R4: In a bus cycle that is not an address phase, this agent is the data source when it is the initiator of a write (`is_master`=1, `is_write`=1) or the target of a read (`is_master`=0, `is_write`=0). As source, it raises `par_oe` in the next cycle if its ready strobe is low in this cycle (`irdy_n` for writes, `trdy_n` for reads). Otherwise `par_oe` is 0 in the next cycle.
- R5: A data phase completes in cycle k when `irdy_n` and `trdy_n` are both low. If this agent is the receiver and `devsel_n` is low in cycle k, then in cycle k+2 `perr_oe` is 1 and `perr_n` is 0 exactly when the `par_in` of cycle k+1 differs from the expected parity.
- R6: A completed phase with `devsel_n` high, or one that this agent sourced, gives `perr_oe`=0 and `perr_n`=1 two cycles later.
- R7: For an address phase in cycle k with `is_master`=0, a `par_in` in cycle k+1 that differs from the address parity drives `serr_n` low and `serr_oe` high in cycle k+2 only. An initiator never raises `serr_n` low.
- R8: When `wide64` is 0 in the completing cycle, `par64_in` is ignored. A wrong `par64_in` alone leaves `perr_n` high.
- R9: `perr_seen` and `serr_seen` rise in the same cycle as their error line and stay set. A one-clock high on `perr_seen_clr` or `serr_seen_clr` clears the flag in the next cycle. A new error that coincides with a clear pulse keeps the flag set.
- R10: While `rst_n` is low, `par_oe`, `par64_oe`, `perr_oe`, `serr_oe`, `perr_seen` and `serr_seen` are 0, and `perr_n` and `serr_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 64 | Sampled address/data bus |
| cbe_n | input | 8 | Sampled command/byte-enable lines |
| frame_n | input | 1 | Frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| is_master | input | 1 | 1 when this agent is the initiator |
| is_write | input | 1 | 1 for a write transfer |
| wide64 | input | 1 | 1 when a 64-bit transfer is negotiated |
| par_in | input | 1 | Sampled low-half parity line |
| par64_in | input | 1 | Sampled full-width parity line |
| perr_seen_clr | input | 1 | Clear pulse for the data-error flag |
| serr_seen_clr | input | 1 | Clear pulse for the address-error flag |
| par_out | output | 1 | Generated low-half parity |
| par_oe | output | 1 | Drive enable for `par_out` |
| par64_out | output | 1 | Generated full-width parity |
| par64_oe | output | 1 | Drive enable for `par64_out` |
| perr_n | output | 1 | Data parity error, active low |
| perr_oe | output | 1 | Drive enable for `perr_n` |
| serr_n | output | 1 | Address parity error, active low |
| serr_oe | output | 1 | Drive enable for `serr_n` |
| perr_seen | output | 1 | Sticky data-error flag |
| serr_seen | output | 1 | Sticky address-error flag |

## Verification
Generated parity and its enables are due one cycle after the bus cycle they describe. Data-error results are due two cycles after the completing data phase, because the returned parity line is itself sampled one cycle late. The address error is due two cycles after the address phase. The sticky flags change in the same cycle as their error line, and one cycle after a clear pulse. The bench drives each bus cycle just after a rising edge, and files every expected value in a queue tagged with its absolute due cycle. The bench compares each queued value at the falling edge of that cycle, so every check samples exactly the cycle the register count fixes.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    typedef struct packed {
        logic par;        // registered low-half parity
        logic par_oe;
        logic par64;      // registered full-width parity
        logic par64_oe;
        logic chk_dat;    // a received, claimed data phase completed last cycle
        logic chk_wide;   // that phase was 64-bit
        logic exp_par;
        logic exp_par64;
        logic chk_adr;    // an address phase seen as target last cycle
        logic exp_apar;
        logic perr;
        logic perr_oe;
        logic serr;
        logic perr_seen;
        logic serr_seen;
    } par_state_t;

    localparam par_state_t PAR_STATE_RST = '0;

endpackage

// File: rtl/pci_par_xor.sv
module pci_par_xor #(
    parameter int W = 36
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    assign odd = ^bits;
endmodule

// File: rtl/pci_par_phase.sv
module pci_par_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    output logic addr_phase,
    output logic data_cyc,
    output logic done
);
    logic idle_d, idle_q;

    always_comb begin
        idle_d = frame_n && irdy_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_q <= 1'b1;
        else        idle_q <= idle_d;
    end

    assign addr_phase = !frame_n && idle_q;
    assign data_cyc   = (!frame_n || !irdy_n) && !addr_phase;
    assign done       = data_cyc && !irdy_n && !trdy_n;
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W  = 64,
    parameter int CBE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             devsel_n,
    input  logic             is_master,
    input  logic             is_write,
    input  logic             wide64,
    input  logic             par_in,
    input  logic             par64_in,
    input  logic             perr_seen_clr,
    input  logic             serr_seen_clr,
    output logic             par_out,
    output logic             par_oe,
    output logic             par64_out,
    output logic             par64_oe,
    output logic             perr_n,
    output logic             perr_oe,
    output logic             serr_n,
    output logic             serr_oe,
    output logic             perr_seen,
    output logic             serr_seen
);
    localparam int LANES  = 2;
    localparam int LANE_AD  = AD_W / LANES;
    localparam int LANE_CBE = CBE_W / LANES;

    logic [LANES-1:0] lane_par;
    logic             p_lo, p_full;
    logic             addr_phase, data_cyc, done;
    logic             source, ready, dat_err, adr_err;
    par_state_t       st_d, st_q;

    // one parity tree per bus half
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pci_par_xor #(.W(LANE_AD + LANE_CBE)) xor_i (
            .bits ({ad[g*LANE_AD +: LANE_AD], cbe_n[g*LANE_CBE +: LANE_CBE]}),
            .odd  (lane_par[g])
        );
    end

    assign p_lo   = lane_par[0];
    assign p_full = ^lane_par;

    pci_par_phase phase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .addr_phase (addr_phase),
        .data_cyc   (data_cyc),
        .done       (done)
    );

    always_comb begin
        source  = is_master ? is_write : !is_write;
        ready   = is_write ? !irdy_n : !trdy_n;
        dat_err = st_q.chk_dat &&
                  ((par_in != st_q.exp_par) ||
                   (st_q.chk_wide && (par64_in != st_q.exp_par64)));
        adr_err = st_q.chk_adr && (par_in != st_q.exp_apar);

        st_d           = st_q;
        st_d.par       = p_lo;
        st_d.par64     = p_full;
        st_d.par_oe    = (addr_phase && is_master) || (data_cyc && source && ready);
        st_d.par64_oe  = data_cyc && source && ready && wide64;
        st_d.chk_dat   = done && !source && !devsel_n;
        st_d.chk_wide  = wide64;
        st_d.exp_par   = p_lo;
        st_d.exp_par64 = p_full;
        st_d.chk_adr   = addr_phase && !is_master;
        st_d.exp_apar  = p_lo;
        st_d.perr      = dat_err;
        st_d.perr_oe   = st_q.chk_dat;
        st_d.serr      = adr_err;
        st_d.perr_seen = dat_err || (st_q.perr_seen && !perr_seen_clr);
        st_d.serr_seen = adr_err || (st_q.serr_seen && !serr_seen_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PAR_STATE_RST;
        else        st_q <= st_d;
    end

    assign par_out   = st_q.par;
    assign par_oe    = st_q.par_oe;
    assign par64_out = st_q.par64;
    assign par64_oe  = st_q.par64_oe;
    assign perr_n    = !st_q.perr;
    assign perr_oe   = st_q.perr_oe;
    assign serr_n    = !st_q.serr;
    assign serr_oe   = st_q.serr;
    assign perr_seen = st_q.perr_seen;
    assign serr_seen = st_q.serr_seen;
endmodule

// File: rtl/pci_parity_chk.sv
module pci_parity_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_n,
    input logic irdy_n,
    input logic trdy_n,
    input logic devsel_n,
    input logic is_master,
    input logic wide64,
    input logic perr_seen_clr,
    input logic par_oe,
    input logic par64_oe,
    input logic perr_n,
    input logic perr_oe,
    input logic serr_n,
    input logic perr_seen
);
    // R3/R4: parity is only driven after a busy bus cycle
    a_r4_oe_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(!frame_n || !irdy_n));

    // R2: wide parity only for negotiated 64-bit transfers
    a_r2_wide_needs_nego: assert property (@(posedge clk) disable iff (!rst_n)
        par64_oe |-> $past(wide64));

    // R5: a low error line is always driven
    a_r5_perr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> perr_oe);

    // R6: error reporting needs a claimed, completed phase two clocks back
    a_r6_perr_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        perr_oe |-> $past(!devsel_n && !irdy_n && !trdy_n, 2));

    // R7: address error lasts one clock and comes only from a target
    a_r7_serr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n);
    a_r7_serr_target_only: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(!is_master, 2));

    // R9: flag stays set without a clear pulse
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_seen && !perr_seen_clr) |=> perr_seen);
endmodule

bind pci_parity_unit pci_parity_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_n       (frame_n),
    .irdy_n        (irdy_n),
    .trdy_n        (trdy_n),
    .devsel_n      (devsel_n),
    .is_master     (is_master),
    .wide64        (wide64),
    .perr_seen_clr (perr_seen_clr),
    .par_oe        (par_oe),
    .par64_oe      (par64_oe),
    .perr_n        (perr_n),
    .perr_oe       (perr_oe),
    .serr_n        (serr_n),
    .perr_seen     (perr_seen)
);

// File: tb/pci_parity_unit_tb_top.sv
module pci_parity_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    // observed vector bit positions
    localparam int B_POE = 9, B_PAR = 8, B_P64OE = 7, B_P64 = 6, B_EOE = 5;
    localparam int B_PERRN = 4, B_SOE = 3, B_SERRN = 2, B_PF = 1, B_SF = 0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [63:0] ad = '0;
    logic [7:0]  cbe_n = '1;
    logic frame_n = 1, irdy_n = 1, trdy_n = 1, devsel_n = 1;
    logic is_master = 0, is_write = 0, wide64 = 0, par_in = 0, par64_in = 0;
    logic perr_seen_clr = 0, serr_seen_clr = 0;
    logic par_out, par_oe, par64_out, par64_oe, perr_n, perr_oe, serr_n, serr_oe;
    logic perr_seen, serr_seen;

    int cyc = 0;
    int compared = 0;
    int mismatched = 0;

    typedef struct {
        int    due;
        int    bidx;
        logic  val;
        string tag;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pci_parity_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .frame_n(frame_n),
        .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
        .is_master(is_master), .is_write(is_write), .wide64(wide64),
        .par_in(par_in), .par64_in(par64_in), .perr_seen_clr(perr_seen_clr),
        .serr_seen_clr(serr_seen_clr), .par_out(par_out), .par_oe(par_oe),
        .par64_out(par64_out), .par64_oe(par64_oe), .perr_n(perr_n),
        .perr_oe(perr_oe), .serr_n(serr_n), .serr_oe(serr_oe),
        .perr_seen(perr_seen), .serr_seen(serr_seen)
    );

    function automatic logic [9:0] obs();
        return {par_oe, par_out, par64_oe, par64_out, perr_oe, perr_n,
                serr_oe, serr_n, perr_seen, serr_seen};
    endfunction

    function automatic logic p32(logic [63:0] a, logic [7:0] c);
        return logic'($countones({a[31:0], c[3:0]}) % 2);
    endfunction

    function automatic logic p64(logic [63:0] a, logic [7:0] c);
        return logic'($countones({a, c}) % 2);
    endfunction

    task automatic check(string tag, int bidx, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s bit%0d cycle %0d: actual %b expected %b", tag, bidx, cyc, act, exp);
        end
    endtask

    task automatic expect_at(int off, int bidx, logic val, string tag);
        item_t it;
        it.due = cyc + off; it.bidx = bidx; it.val = val; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compare every item that is due in this cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    logic [9:0] o;
                    o = obs();
                    check(sb[i].tag, sb[i].bidx, o[sb[i].bidx], sb[i].val);
                    sb.delete(i);
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        if (cyc > 3000) begin
            mismatched++;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        step();
        frame_n = 1; irdy_n = 1; trdy_n = 1; devsel_n = 1;
        par_in = 0; par64_in = 0; perr_seen_clr = 0; serr_seen_clr = 0;
    endtask

    task automatic addr(logic [63:0] a, logic [7:0] c);
        step();
        frame_n = 0; irdy_n = 1; trdy_n = 1; devsel_n = 1;
        ad = a; cbe_n = c; par_in = 0; par64_in = 0;
    endtask

    task automatic data(logic ir_n, logic tr_n, logic ds_n, logic [63:0] a, logic [7:0] c);
        step();
        frame_n = 1; irdy_n = ir_n; trdy_n = tr_n; devsel_n = ds_n;
        ad = a; cbe_n = c;
    endtask

    initial begin
        logic [63:0] d;
        logic [7:0]  e;

        // R10: reset state
        repeat (3) @(posedge clk);
        #5;
        begin
            logic [9:0] o;
            o = obs();
            check("R10 par_oe",   B_POE,   o[B_POE],   1'b0);
            check("R10 par64_oe", B_P64OE, o[B_P64OE], 1'b0);
            check("R10 perr_oe",  B_EOE,   o[B_EOE],   1'b0);
            check("R10 perr_n",   B_PERRN, o[B_PERRN], 1'b1);
            check("R10 serr_n",   B_SERRN, o[B_SERRN], 1'b1);
            check("R10 serr_oe",  B_SOE,   o[B_SOE],   1'b0);
            check("R10 flags",    B_PF,    o[B_PF] | o[B_SF], 1'b0);
        end
        @(posedge clk); #2; rst_n = 1;
        idle();

        // initiator write, 32-bit: R1, R3, R4
        is_master = 1; is_write = 1; wide64 = 0;
        addr(64'h0000_0000_1234_5670, 8'hF3);
        expect_at(1, B_POE, 1'b1, "R3 master addr oe");
        expect_at(1, B_PAR, p32(ad, cbe_n), "R1 addr parity");
        expect_at(1, B_P64OE, 1'b0, "R2 no wide on addr");
        d = 64'hDEAD_BEEF_0F0F_1357; e = 8'h50;
        data(0, 1, 0, d, e);
        expect_at(1, B_POE, 1'b1, "R4 write irdy oe");
        expect_at(1, B_PAR, p32(d, e), "R1 data parity");
        expect_at(1, B_P64OE, 1'b0, "R2 narrow no par64");
        data(0, 0, 0, d, e);
        expect_at(1, B_POE, 1'b1, "R4 hold to completion+1");
        expect_at(2, B_EOE, 1'b0, "R6 sourced phase unchecked");
        idle();
        expect_at(1, B_POE, 1'b0, "R4 release after phase");

        // initiator write, 64-bit: R2
        wide64 = 1;
        idle();
        addr(64'h0000_0001_0000_0040, 8'h07);
        expect_at(1, B_P64OE, 1'b0, "R2 wide addr no par64");
        d = 64'h8000_0001_F00D_0003; e = 8'h01;
        data(0, 0, 0, d, e);
        expect_at(1, B_P64OE, 1'b1, "R2 wide par64 oe");
        expect_at(1, B_P64, p64(d, e), "R2 par64 value");
        expect_at(1, B_PAR, p32(d, e), "R1 wide low parity");
        idle();

        // target write, 64-bit, bad par64: R5, R7 (good addr), R4, R9
        is_master = 0; is_write = 1; wide64 = 1;
        idle();
        addr(64'h0000_0000_AAAA_0000, 8'hF7);
        expect_at(1, B_POE, 1'b0, "R3 target no addr oe");
        begin
            logic ap;
            ap = p32(ad, cbe_n);
            d = 64'h0123_4567_89AB_CDEF; e = 8'h00;
            data(0, 0, 0, d, e);
            par_in = ap;
        end
        expect_at(1, B_POE, 1'b0, "R4 target write not source");
        expect_at(1, B_SERRN, 1'b1, "R7 good addr parity");
        expect_at(2, B_EOE, 1'b1, "R5 perr driven");
        expect_at(2, B_PERRN, 1'b0, "R5 par64 mismatch");
        expect_at(2, B_PF, 1'b1, "R9 perr flag set");
        idle();
        par_in = p32(d, e); par64_in = ~p64(d, e);
        idle();

        // target write, 32-bit, bad par64 only: R8
        wide64 = 0;
        addr(64'h0000_0000_AAAA_0010, 8'hF7);
        begin
            logic ap;
            ap = p32(ad, cbe_n);
            d = 64'hFFFF_0000_1111_2222; e = 8'hC0;
            data(0, 0, 0, d, e);
            par_in = ap;
        end
        expect_at(2, B_EOE, 1'b1, "R8 narrow checked");
        expect_at(2, B_PERRN, 1'b1, "R8 upper ignored");
        idle();
        par_in = p32(d, e); par64_in = ~p64(d, e);
        idle();

        // initiator read, bad low parity: R5, R7 (initiator never), R4
        is_master = 1; is_write = 0;
        addr(64'h0000_0000_0000_0100, 8'hF6);
        expect_at(1, B_POE, 1'b1, "R3 master read addr oe");
        begin
            logic ap;
            ap = p32(ad, cbe_n);
            d = 64'h0000_0000_7777_0001; e = 8'h00;
            data(0, 0, 0, d, e);
            par_in = ~ap;
        end
        expect_at(1, B_SERRN, 1'b1, "R7 initiator no serr");
        expect_at(1, B_POE, 1'b0, "R4 master read not source");
        expect_at(2, B_EOE, 1'b1, "R5 read checked");
        expect_at(2, B_PERRN, 1'b0, "R5 par mismatch");
        idle();
        par_in = ~p32(d, e);
        idle();

        // unclaimed phase: R6
        is_master = 0; is_write = 1;
        addr(64'h0000_0000_0000_0200, 8'hF7);
        begin
            logic ap;
            ap = p32(ad, cbe_n);
            d = 64'h0000_0000_0000_00FF; e = 8'h00;
            data(0, 0, 1, d, e);
            par_in = ap;
        end
        expect_at(2, B_EOE, 1'b0, "R6 unclaimed no oe");
        expect_at(2, B_PERRN, 1'b1, "R6 unclaimed no perr");
        idle();
        par_in = ~p32(d, e);
        idle();

        // address parity error as target: R7, R9
        addr(64'h0000_0000_BEEF_0000, 8'hF7);
        expect_at(2, B_SERRN, 1'b0, "R7 serr low");
        expect_at(2, B_SOE, 1'b1, "R7 serr driven");
        expect_at(2, B_SF, 1'b1, "R9 serr flag set");
        expect_at(3, B_SERRN, 1'b1, "R7 one clock only");
        begin
            logic ap;
            ap = p32(ad, cbe_n);
            idle();
            par_in = ~ap;
        end
        idle();
        idle();

        // sticky flags: R9
        expect_at(1, B_PF, 1'b1, "R9 perr flag held");
        step(); perr_seen_clr = 1;
        expect_at(1, B_PF, 1'b0, "R9 perr cleared");
        expect_at(1, B_SF, 1'b1, "R9 serr untouched");
        idle();
        // error coinciding with a clear pulse keeps the flag
        addr(64'h0000_0000_0000_0300, 8'hF7);
        begin
            logic ap;
            ap = p32(ad, cbe_n);
            d = 64'h0000_0000_0000_0001; e = 8'h00;
            data(0, 0, 0, d, e);
            par_in = ap;
        end
        expect_at(2, B_PF, 1'b1, "R9 set wins over clear");
        idle();
        par_in = ~p32(d, e); perr_seen_clr = 1;
        step(); serr_seen_clr = 1; perr_seen_clr = 0; par_in = 0;
        expect_at(1, B_SF, 1'b0, "R9 serr cleared");
        idle();

        // target read: R4 trdy rule, R6 sourced
        is_master = 0; is_write = 0;
        addr(64'h0000_0000_0000_0400, 8'hF6);
        expect_at(1, B_POE, 1'b0, "R3 target read addr");
        d = 64'h0000_0000_5A5A_A5A5; e = 8'h00;
        data(0, 1, 0, d, e);
        expect_at(1, B_POE, 1'b0, "R4 trdy not yet low");
        data(0, 0, 0, d, e);
        expect_at(1, B_POE, 1'b1, "R4 trdy low drives");
        expect_at(1, B_PAR, p32(d, e), "R1 read data parity");
        expect_at(2, B_EOE, 1'b0, "R6 target read unchecked");
        idle();
        expect_at(1, B_POE, 1'b0, "R4 release after read");

        repeat (5) idle();
        if (sb.size() != 0) begin
            mismatched += sb.size();
            $display("FAIL scoreboard: %0d items never compared", sb.size());
        end
        summary();
        $finish;
    end
endmodule